// File: doc/BRIEF.md
# Word-Serial Burst Address-Event Receiver

This block takes address events from a single shared word bus and turns them into row-parallel writes into a two-dimensional cell array. A burst opens with one row word. Any number of column words follow, one for each active cell in that row. Each column word is decoded into a one-hot bit as soon as it is accepted. That bit is merged into a row-wide mask.

A burst ends in one of two ways: a column word arrives with its tail flag set, or a new row word arrives. When the burst ends, its mask and row index move to a write stage. The write stage presents them as one parallel write on a valid/ready row-write port. There are two buffers: one gathers the current burst and one holds the write. Because of this, the next burst can be decoded while the previous row write is still waiting or in progress. Only one row write is ever outstanding.

The input side also uses valid/ready. Ready drops only when a completed burst cannot move into the write stage, because that stage is still occupied.

Top module: `ws_burst_rx`

## Requirements
- R1: After reset, `in_ready` is high and `wr_valid` is low. An accepted row word (`in_is_row`=1) with no burst open opens a burst for row `in_addr`.
- R2: Each column word (`in_is_row`=0) accepted into an open burst sets bit `in_addr` of that burst's mask. Bit 0 is column 0.
- R3: A column word accepted with `in_last`=1 closes the burst. The burst's row and mask are then presented once on `wr_row`/`wr_mask`.
- R4: A row word accepted while a burst is open closes that burst, which is written with its mask. The same row word opens a new burst for its own row.
- R5: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_row` and `wr_mask` hold their values. The write buffer is freed only on the cycle where both are high.
- R6: Column words of the next burst are accepted while the previous burst's write is pending.
- R7: If a burst is closed by a tail word while the write stage is occupied, `in_ready` stays low until that burst has moved into the write stage. A row word that would close an open burst is refused while the write stage is occupied.
- R8: A column word accepted while no burst is open is discarded. This includes the case after reset and the case after a tail close. `err_orphan` is high for exactly the one cycle after the acceptance, and no write results.
- R9: Synchronous active-high `rst` empties both buffers. After it, `wr_valid` is low, `in_ready` is high and no burst is open.
- R10: A burst with no column words is still written, with an all-zero mask.
- R11: Repeating a column address within a burst sets the same bit only once.
- R12: Bursts are written in the order they were closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high together with in_valid |
| in_is_row | input | 1 | 1: row word, 0: column word |
| in_last | input | 1 | Tail flag on the final column word of a burst |
| in_addr | input | WORD_W | Row or column address |
| wr_valid | output | 1 | Row write pending |
| wr_ready | input | 1 | Array takes the row write |
| wr_row | output | ROW_AW | Row index of the write |
| wr_mask | output | NUM_COLS | Column mask of the write |
| err_orphan | output | 1 | One-cycle pulse for a discarded column word |

## Verification
Several properties are checked on every cycle by assertions:
- the write port holds stable under back-pressure;
- the write stage is loaded only while it is empty;
- an accepted column word always leaves its bit set in the gather mask;
- a completed burst waits only because the write stage was full;
- every error pulse follows an accepted column word.

Some behaviour can only be shown by the bench's scenarios, because it depends on the ordering of whole bursts:
- the exact sequence of written rows and masks across all 256 column patterns;
- empty bursts;
- duplicate columns;
- the two ways of closing a burst;
- the refusal of a closing row word under back-pressure;
- loss of pending work on reset.

// File: rtl/ws_rx_pkg.sv
package ws_rx_pkg;

  // Address width for a count of n items, never below one bit.
  function automatic int addr_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Wider of two widths.
  function automatic int max_width(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ws_rx_coldec.sv
module ws_rx_coldec
  import ws_rx_pkg::*;
#(
  parameter int NUM_COLS = 8,
  localparam int COL_AW = addr_bits(NUM_COLS)
) (
  input  logic [COL_AW-1:0]   col,
  output logic [NUM_COLS-1:0] onehot
);

  for (genvar i = 0; i < NUM_COLS; i++) begin : g_bit
    assign onehot[i] = (col == COL_AW'(i));
  end

endmodule

// File: rtl/ws_rx_gather.sv
module ws_rx_gather
  import ws_rx_pkg::*;
#(
  parameter int NUM_ROWS = 8,
  parameter int NUM_COLS = 8,
  localparam int ROW_AW = addr_bits(NUM_ROWS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic                in_is_row,
  input  logic                in_last,
  input  logic [ROW_AW-1:0]   in_row,
  input  logic [NUM_COLS-1:0] col_dec,
  input  logic                w_full,
  output logic                in_ready,
  output logic                push,
  output logic [ROW_AW-1:0]   push_row,
  output logic [NUM_COLS-1:0] push_mask,
  output logic                orphan
);

  logic                g_open;
  logic                g_done;
  logic [ROW_AW-1:0]   g_row;
  logic [NUM_COLS-1:0] g_mask;

  logic accept;
  logic col_into_open;
  logic close_now;
  logic push_now;
  logic push_late;

  assign in_ready      = !g_done && !(in_is_row && g_open && w_full);
  assign accept        = in_valid && in_ready;
  assign col_into_open = accept && !in_is_row && g_open;
  assign close_now     = accept && g_open && (in_is_row || in_last);
  assign push_now      = close_now && !w_full;
  assign push_late     = g_done && !w_full;
  assign push          = push_now || push_late;
  assign push_row      = g_row;
  assign push_mask     = (push_late || in_is_row) ? g_mask : (g_mask | col_dec);
  assign orphan        = accept && !in_is_row && !g_open;

  always_ff @(posedge clk) begin
    if (rst) begin
      g_open <= 1'b0;
      g_done <= 1'b0;
      g_row  <= '0;
      g_mask <= '0;
    end else if (push_late) begin
      g_open <= 1'b0;
      g_done <= 1'b0;
    end else if (accept) begin
      if (in_is_row) begin
        g_open <= 1'b1;
        g_row  <= in_row;
        g_mask <= '0;
      end else if (g_open) begin
        g_mask <= g_mask | col_dec;
        if (in_last) begin
          if (w_full) g_done <= 1'b1;
          else        g_open <= 1'b0;
        end
      end
    end
  end

  // R2
  col_bit_set_chk: assert property (@(posedge clk) disable iff (rst)
    col_into_open |=> ((g_mask & $past(col_dec)) == $past(col_dec)));

  // R7
  done_needs_full_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(g_done) |-> $past(w_full));

endmodule

// File: rtl/ws_rx_wrbuf.sv
module ws_rx_wrbuf
  import ws_rx_pkg::*;
#(
  parameter int NUM_ROWS = 8,
  parameter int NUM_COLS = 8,
  localparam int ROW_AW = addr_bits(NUM_ROWS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [ROW_AW-1:0]   load_row,
  input  logic [NUM_COLS-1:0] load_mask,
  input  logic                wr_ready,
  output logic                wr_valid,
  output logic [ROW_AW-1:0]   wr_row,
  output logic [NUM_COLS-1:0] wr_mask,
  output logic                full
);

  logic w_full;
  logic fire;

  assign fire     = w_full && wr_ready;
  assign wr_valid = w_full;
  assign full     = w_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      w_full  <= 1'b0;
      wr_row  <= '0;
      wr_mask <= '0;
    end else if (load) begin
      w_full  <= 1'b1;
      wr_row  <= load_row;
      wr_mask <= load_mask;
    end else if (fire) begin
      w_full  <= 1'b0;
    end
  end

  // R5
  wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_row) && $stable(wr_mask)));

  // R6
  load_only_empty_chk: assert property (@(posedge clk) disable iff (rst)
    load |-> !w_full);

endmodule

// File: rtl/ws_burst_rx.sv
module ws_burst_rx
  import ws_rx_pkg::*;
#(
  parameter int NUM_ROWS = 8,
  parameter int NUM_COLS = 8,
  localparam int ROW_AW = addr_bits(NUM_ROWS),
  localparam int COL_AW = addr_bits(NUM_COLS),
  localparam int WORD_W = max_width(ROW_AW, COL_AW)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic                in_is_row,
  input  logic                in_last,
  input  logic [WORD_W-1:0]   in_addr,
  output logic                wr_valid,
  input  logic                wr_ready,
  output logic [ROW_AW-1:0]   wr_row,
  output logic [NUM_COLS-1:0] wr_mask,
  output logic                err_orphan
);

  logic [NUM_COLS-1:0] col_dec;
  logic                w_full;
  logic                push;
  logic [ROW_AW-1:0]   push_row;
  logic [NUM_COLS-1:0] push_mask;
  logic                orphan;

  ws_rx_coldec #(.NUM_COLS(NUM_COLS)) u_dec (
    .col    (in_addr[COL_AW-1:0]),
    .onehot (col_dec)
  );

  ws_rx_gather #(.NUM_ROWS(NUM_ROWS), .NUM_COLS(NUM_COLS)) u_gather (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_is_row (in_is_row),
    .in_last   (in_last),
    .in_row    (in_addr[ROW_AW-1:0]),
    .col_dec   (col_dec),
    .w_full    (w_full),
    .in_ready  (in_ready),
    .push      (push),
    .push_row  (push_row),
    .push_mask (push_mask),
    .orphan    (orphan)
  );

  ws_rx_wrbuf #(.NUM_ROWS(NUM_ROWS), .NUM_COLS(NUM_COLS)) u_wrbuf (
    .clk       (clk),
    .rst       (rst),
    .load      (push),
    .load_row  (push_row),
    .load_mask (push_mask),
    .wr_ready  (wr_ready),
    .wr_valid  (wr_valid),
    .wr_row    (wr_row),
    .wr_mask   (wr_mask),
    .full      (w_full)
  );

  always_ff @(posedge clk) begin
    if (rst) err_orphan <= 1'b0;
    else     err_orphan <= orphan;
  end

  // R8
  orphan_err_chk: assert property (@(posedge clk) disable iff (rst)
    err_orphan |-> $past(in_valid && in_ready && !in_is_row));

endmodule

// File: tb/ws_burst_rx_bench.sv
module ws_burst_rx_bench;

  localparam int NR = 8;
  localparam int NC = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic       in_is_row = 1'b0;
  logic       in_last = 1'b0;
  logic [2:0] in_addr = '0;
  logic       wr_valid;
  logic       wr_ready;
  logic [2:0] wr_row;
  logic [7:0] wr_mask;
  logic       err_orphan;

  logic thr_mode = 1'b0;
  logic thr_bit  = 1'b0;
  logic wr_hold  = 1'b1;
  int   cyc = 0;

  int checks = 0;
  int errors = 0;

  int   log_n = 0;
  int   exp_n = 0;
  int   log_row  [0:1023];
  int   log_mask [0:1023];
  int   exp_row  [0:1023];
  int   exp_mask [0:1023];

  always #2.5 clk = ~clk;

  assign wr_ready = thr_mode ? thr_bit : wr_hold;

  ws_burst_rx #(.NUM_ROWS(NR), .NUM_COLS(NC)) u_ws_burst_rx (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_is_row(in_is_row), .in_last(in_last), .in_addr(in_addr),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_row(wr_row),
    .wr_mask(wr_mask), .err_orphan(err_orphan)
  );

  always @(negedge clk) begin
    cyc = cyc + 1;
    thr_bit = ((cyc % 3) != 0);
    #1;
    if (!rst && wr_valid && wr_ready && log_n < 1024) begin
      log_row[log_n]  = int'(wr_row);
      log_mask[log_n] = int'(wr_mask);
      log_n = log_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic expect_wr(input int r, input int m);
    exp_row[exp_n]  = r;
    exp_mask[exp_n] = m;
    exp_n++;
  endtask

  // R12 ordering plus each entry
  task automatic compare_log(input string req);
    chk(log_n == exp_n, req, log_n, exp_n);
    for (int i = 0; i < exp_n && i < log_n; i++) begin
      chk(log_row[i] == exp_row[i], req, log_row[i], exp_row[i]);
      chk(log_mask[i] == exp_mask[i], req, log_mask[i], exp_mask[i]);
    end
    log_n = 0;
    exp_n = 0;
  endtask

  // called at a negedge; returns at a negedge
  task automatic send(input bit is_row, input bit last, input int addr);
    in_valid  = 1'b1;
    in_is_row = is_row;
    in_last   = last;
    in_addr   = 3'(addr);
    forever begin
      bit r;
      #1 r = in_ready;
      @(posedge clk);
      if (r) break;
      @(negedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    log_n = 0;
    exp_n = 0;
  endtask

  task automatic run_all();
    @(negedge clk);
    do_reset();
    #1;
    // R1 / R9 reset state
    chk(in_ready == 1'b1, "R1 ready after reset", int'(in_ready), 1);
    chk(wr_valid == 1'b0, "R9 wr_valid after reset", int'(wr_valid), 0);
    chk(err_orphan == 1'b0, "R9 err after reset", int'(err_orphan), 0);
    @(negedge clk);

    // Sweep all 256 column patterns (R2 R3 R4 R10 R12), throttled writes
    thr_mode = 1'b1;
    for (int m = 0; m < 256; m++) begin
      int  r = m % NR;
      int  cnt = $countones(m);
      bit  tail = ((m % 2 == 0) || m == 255) && (cnt != 0);
      int  seen = 0;
      send(1'b1, 1'b0, r);
      for (int c = 0; c < NC; c++) begin
        if (m[c]) begin
          seen++;
          send(1'b0, tail && (seen == cnt), c);
        end
      end
      expect_wr(r, m);
    end
    idle(12);
    thr_mode = 1'b0;
    wr_hold  = 1'b1;
    idle(2);
    compare_log("R2 R3 R4 R10 R12 sweep");

    // Back-pressure: overlap and ready drop (R5 R6 R7)
    wr_hold = 1'b0;
    send(1'b1, 1'b0, 1);
    send(1'b0, 1'b1, 2);
    send(1'b1, 1'b0, 3);
    send(1'b0, 1'b0, 5);  // R6 accepted while write pending
    send(1'b0, 1'b1, 6);
    #1;
    chk(in_ready == 1'b0, "R7 ready low after blocked tail", int'(in_ready), 0);
    chk(wr_valid == 1'b1, "R5 write pending", int'(wr_valid), 1);
    chk(int'(wr_row) == 1, "R5 row held", int'(wr_row), 1);
    chk(int'(wr_mask) == 8'h04, "R5 mask held", int'(wr_mask), 4);
    idle(3);
    #1;
    chk(int'(wr_mask) == 8'h04 && wr_valid, "R5 mask stable under stall", int'(wr_mask), 4);
    @(negedge clk);
    wr_hold = 1'b1;
    @(negedge clk); #1;
    chk(in_ready == 1'b0, "R7 ready still low one cycle after handshake", int'(in_ready), 0);
    @(negedge clk); #1;
    chk(in_ready == 1'b1, "R7 ready back once write stage takes burst", int'(in_ready), 1);
    chk(int'(wr_row) == 3 && int'(wr_mask) == 8'h60, "R6 second burst presented", int'(wr_mask), 8'h60);
    @(negedge clk);
    idle(3);
    expect_wr(1, 8'h04);
    expect_wr(3, 8'h60);
    compare_log("R6 R12 overlap order");

    // Closing row word refused while write stage full (R7 R4)
    wr_hold = 1'b0;
    send(1'b1, 1'b0, 0);
    send(1'b0, 1'b1, 1);
    send(1'b1, 1'b0, 2);
    send(1'b0, 1'b0, 7);
    in_valid = 1'b1; in_is_row = 1'b1; in_last = 1'b0; in_addr = 3'd4;
    #1;
    chk(in_ready == 1'b0, "R7 closing row word refused", int'(in_ready), 0);
    @(negedge clk); #1;
    chk(in_ready == 1'b0, "R7 closing row word still refused", int'(in_ready), 0);
    @(negedge clk);
    in_valid = 1'b0;
    wr_hold = 1'b1;
    idle(2);
    send(1'b1, 1'b0, 4);
    send(1'b0, 1'b1, 3);
    idle(4);
    expect_wr(0, 8'h02);
    expect_wr(2, 8'h80);
    expect_wr(4, 8'h08);
    compare_log("R4 R7 row close under back-pressure");

    // Duplicate columns (R11) and explicit empty burst (R10)
    send(1'b1, 1'b0, 6);
    send(1'b0, 1'b0, 1);
    send(1'b0, 1'b0, 1);
    send(1'b0, 1'b1, 4);
    send(1'b1, 1'b0, 5);
    send(1'b1, 1'b0, 2);
    send(1'b0, 1'b1, 0);
    idle(4);
    expect_wr(6, 8'h12);
    expect_wr(5, 8'h00);
    expect_wr(2, 8'h01);
    compare_log("R10 R11 duplicate and empty");

    // Orphan column after tail close (R8)
    send(1'b0, 1'b0, 3);
    #1;
    chk(err_orphan == 1'b1, "R8 err pulse after tail close", int'(err_orphan), 1);
    @(negedge clk); #1;
    chk(err_orphan == 1'b0, "R8 err pulse one cycle", int'(err_orphan), 0);
    idle(3);
    compare_log("R8 no write from orphan");

    // Reset mid-activity (R9), then orphan after reset (R8)
    wr_hold = 1'b0;
    send(1'b1, 1'b0, 7);
    send(1'b0, 1'b1, 5);
    send(1'b1, 1'b0, 1);
    send(1'b0, 1'b0, 2);
    do_reset();
    #1;
    chk(wr_valid == 1'b0, "R9 write stage cleared", int'(wr_valid), 0);
    chk(in_ready == 1'b1, "R9 ready after reset", int'(in_ready), 1);
    @(negedge clk);
    wr_hold = 1'b1;
    send(1'b0, 1'b1, 2);
    #1;
    chk(err_orphan == 1'b1, "R8 column after reset discarded", int'(err_orphan), 1);
    idle(4);
    compare_log("R8 R9 nothing written after reset");
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule